// File: doc/BRIEF.md
# Data Access Exception Checker

This block sits beside the load/store stage of a small processor core. For every data access the stage presents, it checks two things: whether the effective address is aligned to the access size, and, when stack checking is switched on, whether the address lies inside an unsigned window bounded by a low and a high limit. When either check fails, the block captures the faulting address and builds a status word that names the cause. It can also raise a one-cycle exception request toward the core's trap logic.

The two causes behave differently. A misaligned access always records its address and status. It requests a trap only while the exception-enable input is high. A stack-window violation always records and always requests a trap. When one access fails both checks, the misalignment report wins. The recorded registers keep their contents until the next reported fault or a reset, so trap software can read them at leisure. Deciding where a trap goes, and handling bus errors, belong to other blocks.

Top module: `dacc_exc_guard`

## Requirements
- R1: After reset, `exc_addr` and `exc_status` are zero and `exc_req` is low.
- R2: The access size is encoded on `acc_size` as 00 byte, 01 halfword, 10 word and 11 treated as word. A halfword is misaligned when address bit 0 is set. A word is misaligned when address bits 1:0 are nonzero. A byte is never misaligned.
- R3: On the clock edge that samples a faulting access (`acc_valid` high), `exc_addr` loads that access's address. The new value is visible after that edge.
- R4: A misalignment status word holds cause 5'b00001 in bits 4:0, the register number in bits 9:5, the write flag in bit 10, and a 1 in bit 11 exactly when the access is word sized. All other bits are zero.
- R5: A misalignment drives `exc_req` high for the single cycle after the sampling edge only if `exc_enable` is 1. With `exc_enable` at 0, the address and status registers still update but `exc_req` stays low.
- R6: With `stk_chk_en` high, an aligned access whose address is below `stk_lo` or above `stk_hi` is a stack violation. It loads the address, sets the status word to cause 5'b00111 with all other bits zero, and raises `exc_req` whatever the value of `exc_enable`.
- R7: The limit comparisons are unsigned, and an address equal to either limit is inside the window. With `stk_chk_en` low, no stack violation is reported.
- R8: When an access is both misaligned and outside the stack window, the misalignment report of R4 is recorded, and `exc_req` follows `exc_enable` as in R5.
- R9: With `acc_valid` low, or on an access that raises no fault, the registers keep their values and `exc_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | ADDR_W | Effective address of the access |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_reg | input | 5 | Destination or source register number |
| stk_chk_en | input | 1 | Enables the stack-window check |
| stk_lo | input | ADDR_W | Lowest permitted address (inclusive) |
| stk_hi | input | ADDR_W | Highest permitted address (inclusive) |
| exc_enable | input | 1 | Lets misalignment raise a trap request |
| exc_addr | output | ADDR_W | Address of the last reported fault |
| exc_status | output | STAT_W | Status word of the last reported fault |
| exc_req | output | 1 | One-cycle trap request |

## Verification
The hardest case to reach is an access that fails both checks at once with trapping disabled. The correct result there is a misalignment record with no request, while a stack violation on its own would have forced a request. The bench builds this case on purpose. It programs a stack window, then presents a word access that is both below the window and off its word boundary, once with `exc_enable` low and once with it high. It also probes addresses that sit exactly on the limits, and an address whose top bit is set. That last address would land outside the window under a signed compare but is inside it under the unsigned one.

// File: rtl/dacc_exc_pkg.sv
package dacc_exc_pkg;

   // Access-size encoding presented by the load/store stage
   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;
   localparam logic [1:0] SZ_WIDE = 2'b11;   // reserved, treated as word

   // Fixed field layout of the status word (decoded by trap software)
   localparam int CAUSE_W      = 5;
   localparam int REGNO_W      = 5;
   localparam int ST_CAUSE_LSB = 0;
   localparam int ST_REG_LSB   = 5;
   localparam int ST_DIR_BIT   = 10;
   localparam int ST_WORD_BIT  = 11;
   localparam int ST_MIN_W     = ST_WORD_BIT + 1;

   localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'b00001;
   localparam logic [CAUSE_W-1:0] CAUSE_STACK     = 5'b00111;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_ALIGN = 2'b01,
      FLT_STACK = 2'b10
   } fault_kind_e;

endpackage

// File: rtl/dacc_align_detect.sv
module dacc_align_detect
   import dacc_exc_pkg::*;
(
   input  logic [1:0] addr_lsb,
   input  logic [1:0] size,
   output logic       misaligned,
   output logic       word_sized
);

   logic [1:0] size_mask;

   always_comb begin
      unique case (size)
         SZ_BYTE: size_mask = 2'b00;
         SZ_HALF: size_mask = 2'b01;
         SZ_WORD: size_mask = 2'b11;
         default: size_mask = 2'b11;
      endcase
   end

   assign misaligned = |(addr_lsb & size_mask);
   assign word_sized = (size == SZ_WORD) || (size == SZ_WIDE);

endmodule

// File: rtl/dacc_stack_limit.sv
module dacc_stack_limit #(
   parameter int ADDR_W = 32
) (
   input  logic              enable,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo_limit,
   input  logic [ADDR_W-1:0] hi_limit,
   output logic              violation
);

   logic below_lo;
   logic above_hi;

   // unsigned compares; both limits are inclusive
   assign below_lo  = addr < lo_limit;
   assign above_hi  = addr > hi_limit;
   assign violation = enable && (below_lo || above_hi);

endmodule

// File: rtl/dacc_exc_report.sv
module dacc_exc_report
   import dacc_exc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic               misaligned,
   input  logic               word_sized,
   input  logic               stack_viol,
   input  logic               write,
   input  logic [REGNO_W-1:0] regno,
   input  logic               trap_en,
   input  logic [ADDR_W-1:0]  addr,
   output logic [ADDR_W-1:0]  rec_addr,
   output logic [STAT_W-1:0]  rec_status,
   output logic               req
);

   fault_kind_e       kind;
   logic [STAT_W-1:0] status_d;
   logic              req_d;

   // misalignment outranks the stack window
   always_comb begin
      if (!valid)
         kind = FLT_NONE;
      else if (misaligned)
         kind = FLT_ALIGN;
      else if (stack_viol)
         kind = FLT_STACK;
      else
         kind = FLT_NONE;
   end

   always_comb begin
      status_d = '0;
      req_d    = 1'b0;
      unique case (kind)
         FLT_ALIGN: begin
            status_d[ST_CAUSE_LSB +: CAUSE_W] = CAUSE_UNALIGNED;
            status_d[ST_REG_LSB   +: REGNO_W] = regno;
            status_d[ST_DIR_BIT]              = write;
            status_d[ST_WORD_BIT]             = word_sized;
            req_d                             = trap_en;
         end
         FLT_STACK: begin
            status_d[ST_CAUSE_LSB +: CAUSE_W] = CAUSE_STACK;
            req_d                             = 1'b1;
         end
         default: begin
            status_d = '0;
            req_d    = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_addr   <= '0;
         rec_status <= '0;
         req        <= 1'b0;
      end else begin
         req <= req_d;
         if (kind != FLT_NONE) begin
            rec_addr   <= addr;
            rec_status <= status_d;
         end
      end
   end

endmodule

// File: rtl/dacc_exc_guard.sv
module dacc_exc_guard
   import dacc_exc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int STAT_W      = 32,
   parameter bit STACK_GUARD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [1:0]         acc_size,
   input  logic               acc_write,
   input  logic [4:0]         acc_reg,
   input  logic               stk_chk_en,
   input  logic [ADDR_W-1:0]  stk_lo,
   input  logic [ADDR_W-1:0]  stk_hi,
   input  logic               exc_enable,
   output logic [ADDR_W-1:0]  exc_addr,
   output logic [STAT_W-1:0]  exc_status,
   output logic               exc_req
);

   // elaboration-time parameter checks
   if (STAT_W < ST_MIN_W) begin : g_bad_stat_w
      $error("dacc_exc_guard: STAT_W must hold the fixed status fields");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("dacc_exc_guard: ADDR_W must be at least 2");
   end

   logic misaligned;
   logic word_sized;
   logic stack_viol;

   dacc_align_detect u_align (
      .addr_lsb   (acc_addr[1:0]),
      .size       (acc_size),
      .misaligned (misaligned),
      .word_sized (word_sized)
   );

   if (STACK_GUARD) begin : g_stack
      dacc_stack_limit #(.ADDR_W(ADDR_W)) u_stack (
         .enable    (stk_chk_en),
         .addr      (acc_addr),
         .lo_limit  (stk_lo),
         .hi_limit  (stk_hi),
         .violation (stack_viol)
      );
   end else begin : g_no_stack
      assign stack_viol = 1'b0;
   end

   dacc_exc_report #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_report (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (acc_valid),
      .misaligned (misaligned),
      .word_sized (word_sized),
      .stack_viol (stack_viol),
      .write      (acc_write),
      .regno      (acc_reg),
      .trap_en    (exc_enable),
      .addr       (acc_addr),
      .rec_addr   (exc_addr),
      .rec_status (exc_status),
      .req        (exc_req)
   );

endmodule

// File: rtl/dacc_exc_guard_sva.sv
module dacc_exc_guard_sva #(
   parameter int ADDR_W      = 32,
   parameter int STAT_W      = 32,
   parameter bit STACK_GUARD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_size,
   input logic [4:0]        acc_reg,
   input logic              stk_chk_en,
   input logic [ADDR_W-1:0] stk_lo,
   input logic [ADDR_W-1:0] stk_hi,
   input logic              exc_enable,
   input logic [ADDR_W-1:0] exc_addr,
   input logic [STAT_W-1:0] exc_status,
   input logic              exc_req
);

   logic bad_align;
   logic out_window;
   assign bad_align  = (acc_size == 2'b01 && acc_addr[0]) ||
                       (acc_size[1] && acc_addr[1:0] != 2'b00);
   assign out_window = stk_chk_en && (acc_addr < stk_lo || acc_addr > stk_hi);

   // R1: the first cycle out of reset shows cleared outputs
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (exc_req == 1'b0 && exc_addr == '0 && exc_status == '0));

   // R3: a request always carries the address sampled one edge earlier
   a_r3_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> exc_addr == $past(acc_addr));

   // R4: an unaligned record carries the register number of its access
   a_r4_regno_field: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && exc_status[4:0] == 5'b00001) |-> exc_status[9:5] == $past(acc_reg));

   // R5: a masked misalignment never requests a trap
   a_r5_masked_align: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && bad_align && !exc_enable) |=> !exc_req);

   // R6: an aligned access outside the window always traps with the stack cause
   a_r6_stack_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (STACK_GUARD && acc_valid && !bad_align && out_window)
         |=> (exc_req && exc_status[4:0] == 5'b00111));

   // R9: without an access nothing moves and no request appears
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ($stable(exc_addr) && $stable(exc_status) && !exc_req));

endmodule

bind dacc_exc_guard dacc_exc_guard_sva #(
   .ADDR_W(ADDR_W), .STAT_W(STAT_W), .STACK_GUARD(STACK_GUARD)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_addr   (acc_addr),
   .acc_size   (acc_size),
   .acc_reg    (acc_reg),
   .stk_chk_en (stk_chk_en),
   .stk_lo     (stk_lo),
   .stk_hi     (stk_hi),
   .exc_enable (exc_enable),
   .exc_addr   (exc_addr),
   .exc_status (exc_status),
   .exc_req    (exc_req)
);

// File: tb/tb_dacc_exc_guard.sv
`timescale 1ns/1ps
module tb_dacc_exc_guard;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        acc_valid;
   logic [31:0] acc_addr;
   logic [1:0]  acc_size;
   logic        acc_write;
   logic [4:0]  acc_reg;
   logic        stk_chk_en;
   logic [31:0] stk_lo;
   logic [31:0] stk_hi;
   logic        exc_enable;
   logic [31:0] exc_addr;
   logic [31:0] exc_status;
   logic        exc_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   dacc_exc_guard dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_write(acc_write), .acc_reg(acc_reg),
      .stk_chk_en(stk_chk_en), .stk_lo(stk_lo), .stk_hi(stk_hi),
      .exc_enable(exc_enable), .exc_addr(exc_addr), .exc_status(exc_status),
      .exc_req(exc_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // presents one access, samples right after the edge that takes it
   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic [4:0] rn, input logic ee);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_size = sz;
      acc_write = wr; acc_reg = rn; exc_enable = ee;
      @(posedge clk); #1;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic window(input logic en, input logic [31:0] lo, input logic [31:0] hi);
      stk_chk_en = en; stk_lo = lo; stk_hi = hi;
   endtask

   task automatic t_reset;
      check("R1 addr", exc_addr, 32'h0);
      check("R1 status", exc_status, 32'h0);
      check("R1 req", {31'h0, exc_req}, 32'h0);
   endtask

   task automatic t_word_misalign;
      window(1'b0, 32'h0, 32'h0);
      access(32'h0000_1002, 2'b10, 1'b1, 5'd17, 1'b1);
      // sampled at the negedge after the capturing edge: request still high
      check("R3 word addr", exc_addr, 32'h0000_1002);
      check("R4 word status", exc_status, 32'h0000_0E21);
      check("R5 word req", {31'h0, exc_req}, 32'h1);
      @(posedge clk); #1;
      check("R5 pulse ends", {31'h0, exc_req}, 32'h0);
   endtask

   task automatic t_half_and_byte;
      access(32'h0000_2001, 2'b01, 1'b0, 5'd3, 1'b1);
      check("R2 half misaligned status", exc_status, 32'h0000_0061);
      check("R2 half req", {31'h0, exc_req}, 32'h1);
      access(32'h0000_2002, 2'b01, 1'b1, 5'd9, 1'b1);
      check("R2 half aligned req", {31'h0, exc_req}, 32'h0);
      check("R2 half aligned hold", exc_addr, 32'h0000_2001);
      access(32'h0000_3003, 2'b00, 1'b1, 5'd9, 1'b1);
      check("R2 byte req", {31'h0, exc_req}, 32'h0);
      check("R2 byte hold status", exc_status, 32'h0000_0061);
      access(32'h0000_4002, 2'b11, 1'b0, 5'd0, 1'b1);
      check("R2 size11 as word", exc_status, 32'h0000_0801);
   endtask

   task automatic t_masked;
      access(32'h0000_5001, 2'b10, 1'b1, 5'd31, 1'b0);
      check("R5 masked addr", exc_addr, 32'h0000_5001);
      check("R5 masked status", exc_status, 32'h0000_0FE1);
      check("R5 masked req", {31'h0, exc_req}, 32'h0);
   endtask

   task automatic t_stack;
      window(1'b1, 32'h0000_1000, 32'h0000_1FFF);
      access(32'h0000_0FFC, 2'b10, 1'b0, 5'd4, 1'b0);
      check("R6 below addr", exc_addr, 32'h0000_0FFC);
      check("R6 below status", exc_status, 32'h0000_0007);
      check("R6 below req", {31'h0, exc_req}, 32'h1);
      access(32'h0000_2000, 2'b00, 1'b1, 5'd8, 1'b1);
      check("R6 above addr", exc_addr, 32'h0000_2000);
      check("R6 above req", {31'h0, exc_req}, 32'h1);
      access(32'h0000_1000, 2'b10, 1'b0, 5'd1, 1'b1);
      check("R7 low edge req", {31'h0, exc_req}, 32'h0);
      access(32'h0000_1FFF, 2'b00, 1'b0, 5'd1, 1'b1);
      check("R7 high edge req", {31'h0, exc_req}, 32'h0);
      check("R7 edges hold", exc_addr, 32'h0000_2000);
      window(1'b0, 32'h0000_1000, 32'h0000_1FFF);
      access(32'h0000_0000, 2'b10, 1'b0, 5'd1, 1'b1);
      check("R7 disabled req", {31'h0, exc_req}, 32'h0);
      window(1'b1, 32'h0000_0010, 32'hFFFF_FFF8);
      access(32'hFFFF_FFF0, 2'b10, 1'b0, 5'd1, 1'b1);
      check("R7 unsigned req", {31'h0, exc_req}, 32'h0);
      check("R7 unsigned hold", exc_addr, 32'h0000_2000);
   endtask

   task automatic t_both;
      window(1'b1, 32'h0000_1000, 32'h0000_1FFF);
      access(32'h0000_0002, 2'b10, 1'b0, 5'd5, 1'b0);
      check("R8 both status", exc_status, 32'h0000_08A1);
      check("R8 both masked req", {31'h0, exc_req}, 32'h0);
      access(32'h0000_0006, 2'b10, 1'b1, 5'd6, 1'b1);
      check("R8 both enabled status", exc_status, 32'h0000_0CC1);
      check("R8 both enabled req", {31'h0, exc_req}, 32'h1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      acc_addr = 32'h0000_0003; acc_size = 2'b10; exc_enable = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      check("R9 idle req", {31'h0, exc_req}, 32'h0);
      check("R9 idle addr", exc_addr, 32'h0000_0006);
      check("R9 idle status", exc_status, 32'h0000_0CC1);
   endtask

   initial begin
      rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_size = 2'b00;
      acc_write = 1'b0; acc_reg = '0; exc_enable = 1'b0;
      stk_chk_en = 1'b0; stk_lo = '0; stk_hi = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_word_misalign();
      t_half_and_byte();
      t_masked();
      t_stack();
      t_both();
      t_idle();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule